// File: doc/BRIEF.md
# Microprogram Sequencer

This block steps a control address register through a writable control store of packed microwords. Each 26-bit word holds a group of control bits that go to the datapath unencoded, a 3-bit field that selects one of eight status inputs, and a 10-bit branch target. On every clock edge out of reset, the selected status bit decides the next address. When that bit is 1, the register takes the branch target. When it is 0, the register steps to the following address.

The control store is a register array with one synchronous write port and one registered read port, so an FPGA can map it to block RAM. Software or a boot engine fills the store while the sequencer is held in reset. Releasing reset starts execution at address 0. The read address is the next address itself, so the registered control bits always belong to the word at the address currently shown on `car_out`.

Top module: `useq_top`

## Requirements
- R1: A microword places its control bits in [25:13], its status select in [12:10] and its branch target in [9:0]. `uop_out` presents bits [25:13] of the word stored at the address shown on `car_out`.
- R2: While `rst` is high at a clock edge, the sequencer goes to address 0. At the first low-reset observation, `car_out` is 0 and `uop_out` shows the control bits of word 0.
- R3: At a clock edge with `rst` low, if `status[sel]` is 1, the address loads the branch target of the current word. Here `sel` is the select field of the current word, and `status` is the value present at that same edge.
- R4: At a clock edge with `rst` low, if the selected status bit is 0, the address increases by one.
- R5: A step from address 1023 with the selected status bit at 0 wraps the address to 0.
- R6: A write on the load port lands only when `rst` is high. Writes issued while the sequencer runs leave the store unchanged.
- R7: A write with `ld_we` high during reset stores `ld_data` at `ld_addr`, and every one of the 1024 addresses can be written and later executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables store loading |
| ld_we | input | 1 | Store write enable |
| ld_addr | input | 10 | Store write address |
| ld_data | input | 26 | Microword to write |
| status | input | 8 | Condition inputs picked by the select field |
| uop_out | output | 13 | Registered control bits of the current microword |
| car_out | output | 10 | Current control address |

## Verification
The hardest state to reach from the ports is a write that arrives while the sequencer is running. Its effect only shows once the disturbed address is executed again. The stimulus drives the load port with inverted words at every address during a full sequential pass. It then resets and makes another full pass, comparing every control field with the original program. The wrap from 1023 to 0 is reached by holding all status inputs low for more than 1024 cycles. Pseudo-random status patterns mix branches and steps across the whole store.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UOP_W_DEF  = 13;
  localparam int SEL_W_DEF  = 3;
  localparam int ADDR_W_DEF = 10;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int WORD_W = 26,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/useq_cond_sel.sv
module useq_cond_sel #(
  parameter int SEL_W = 3
) (
  input  logic [(1<<SEL_W)-1:0] status,
  input  logic [SEL_W-1:0]      sel,
  output logic                  hit
);
  localparam int NCOND = 1 << SEL_W;

  logic [NCOND-1:0] pick;

  for (genvar g = 0; g < NCOND; g++) begin : g_pick
    assign pick[g] = status[g] && (sel == SEL_W'(g));
  end

  assign hit = |pick;
endmodule

// File: rtl/useq_car.sv
module useq_car #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] car,
  output logic [ADDR_W-1:0] car_nxt
);
  always_comb begin
    if (rst)      car_nxt = '0;
    else if (hit) car_nxt = target;
    else          car_nxt = car + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    car <= car_nxt;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top #(
  parameter int UOP_W  = useq_pkg::UOP_W_DEF,
  parameter int SEL_W  = useq_pkg::SEL_W_DEF,
  parameter int ADDR_W = useq_pkg::ADDR_W_DEF
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ld_we,
  input  logic [ADDR_W-1:0]               ld_addr,
  input  logic [UOP_W+SEL_W+ADDR_W-1:0]   ld_data,
  input  logic [(1<<SEL_W)-1:0]           status,
  output logic [UOP_W-1:0]                uop_out,
  output logic [ADDR_W-1:0]               car_out
);
  localparam int WORD_W  = UOP_W + SEL_W + ADDR_W;
  localparam int SEL_LO  = ADDR_W;
  localparam int UOP_LO  = ADDR_W + SEL_W;

  logic [WORD_W-1:0] word_q;
  logic [ADDR_W-1:0] car_nxt;
  logic [ADDR_W-1:0] nxt_field;
  logic [SEL_W-1:0]  sel_field;
  logic              hit;

  assign nxt_field = word_q[ADDR_W-1:0];
  assign sel_field = word_q[UOP_LO-1:SEL_LO];
  assign uop_out   = word_q[WORD_W-1:UOP_LO];

  useq_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_store (
    .clk   (clk),
    .we    (ld_we & rst),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (car_nxt),
    .rdata (word_q)
  );

  useq_cond_sel #(.SEL_W(SEL_W)) i_cond (
    .status (status),
    .sel    (sel_field),
    .hit    (hit)
  );

  useq_car #(.ADDR_W(ADDR_W)) i_car (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .target  (nxt_field),
    .car     (car_out),
    .car_nxt (car_nxt)
  );
endmodule

// File: rtl/useq_check.sv
module useq_check #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              hit,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] car
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> car == '0); // R2
  AST_BRANCH_TAKEN: assert property (@(posedge clk) disable iff (rst)
    hit |=> car == $past(target)); // R3
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (car - $past(car)) == ADDR_W'(1)); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!hit && car == {ADDR_W{1'b1}}) |=> car == '0); // R5
endmodule

bind useq_top useq_check #(.ADDR_W(ADDR_W)) i_useq_check (
  .clk    (clk),
  .rst    (rst),
  .hit    (hit),
  .target (nxt_field),
  .car    (car_out)
);

// File: tb/test_useq_top.sv
module test_useq_top;
  localparam int PERIOD = 8;
  localparam int DEPTH  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic [9:0]  ld_addr = '0;
  logic [25:0] ld_data = '0;
  logic [7:0]  status = '0;
  logic [12:0] uop_out;
  logic [9:0]  car_out;

  int checks = 0;
  int errors = 0;
  int m_car  = 0;
  logic [7:0] lfsr = 8'h5a;

  always #(PERIOD/2) clk = ~clk;

  useq_top i_useq_top (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .status(status), .uop_out(uop_out), .car_out(car_out)
  );

  function automatic logic [12:0] p_uop(int a); return 13'(a * 37 + 5); endfunction
  function automatic logic [2:0]  p_sel(int a); return 3'(a); endfunction
  function automatic logic [9:0]  p_nxt(int a); return 10'(a * 7 + 3); endfunction
  function automatic logic [25:0] p_word(int a);
    return {p_uop(a), p_sel(a), p_nxt(a)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(int n, int mode, bit scribble, string uop_req);
    string car_req = "R2";
    for (int i = 0; i < n; i++) begin
      chk(car_out == 10'(m_car), car_req, int'(car_out), m_car);
      chk(uop_out == p_uop(m_car), uop_req, int'(uop_out), int'(p_uop(m_car)));
      case (mode)
        0: status = 8'h00;
        1: status = 8'hff;
        default: begin
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          status = lfsr;
        end
      endcase
      if (scribble) begin
        ld_we = 1'b1; ld_addr = 10'(i); ld_data = ~p_word(i % DEPTH);
      end
      if (status[p_sel(m_car)]) begin
        m_car = int'(p_nxt(m_car)); car_req = "R3";
      end else if (m_car == DEPTH - 1) begin
        m_car = 0; car_req = "R5";
      end else begin
        m_car = m_car + 1; car_req = "R4";
      end
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic reset_and_check();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(car_out == 10'd0, "R2", int'(car_out), 0);
    chk(uop_out == p_uop(0), "R2", int'(uop_out), int'(p_uop(0)));
    m_car = 0;
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R7: fill every address while held in reset
    for (int a = 0; a < DEPTH; a++) begin
      ld_we = 1'b1; ld_addr = 10'(a); ld_data = p_word(a);
      @(negedge clk);
    end
    ld_we = 1'b0;
    reset_and_check();
    run(1100, 0, 1'b1, "R7");   // sequential sweep with wrap, stray writes (R6)
    reset_and_check();
    run(1100, 0, 1'b0, "R6");   // store must still hold the original program
    run(700, 1, 1'b0, "R1");    // always branch
    run(2000, 2, 1'b0, "R1");   // mixed branch/step
    reset_and_check();
    run(300, 2, 1'b0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule